// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

The block watches one demodulated infrared receiver line and turns the pattern of marks and spaces into byte-wide run-length codes. The line passes through a two-stage synchronizer and can be inverted before use, so that an active-low receiver shows its bursts as pulses. It is sampled once every `TICK_DIV` clocks. A glitch filter requires any change of level to persist for a programmable number of samples. The filtered level is then run-length encoded.

A packet opens at the first pulse after reset, after an idle timeout, or after the block is enabled. It closes when the line has stayed at the space level for a programmable number of 128-sample units. The block then emits a final code and pulses a packet-end strobe in the same cycle. Codes leave as a one-cycle valid strobe with an 8-bit value. Buffering of codes, the register interface and protocol decoding belong to the surrounding logic.

Top module: `ir_run_sampler`

## Requirements
- R1: The line is sampled once every `TICK_DIV` clocks (default 64). A level held for n·`TICK_DIV` clocks is measured as a run of n samples.
- R2: Code bit 7 is the level of the run (1 = pulse, 0 = space). Code bits 6:0 hold the run length in samples minus one.
- R3: When `invertPol` is 1, the synchronized input is inverted before sampling. A low receiver output is then encoded as a pulse, and the codes match those of the non-inverted line.
- R4: A run longer than 128 samples is emitted as full codes with field 0x7F, in order, at the same level, followed by one code for the remainder. A run that is an exact multiple of 128 samples produces no remainder code.
- R5: A change of level is accepted only after it has persisted for `noiseThr` consecutive samples (a value of 0 acts as 1). A shorter excursion is merged into the surrounding run and produces no code.
- R6: When a space run reaches (`idleThr`+1)·128 samples, the block emits the final space code 0x7F with `packetEnd` high in the same cycle. This happens once per packet, and a space that does not reach this length produces no `packetEnd`.
- R7: After reset or after a packet end, the block assumes an idle line. It emits no code until the filtered line goes to the pulse level. The first code of a packet is therefore a pulse code.
- R8: Sampling and encoding run only while `globalEn` and `rxEn` are both 1. Without both, no code and no `packetEnd` appear, and the run state is cleared. A packet interrupted by disabling is dropped.
- R9: During and right after reset, `codeValid`, `packetEnd` and `code` are 0.
- R10: `codeValid` is a one-cycle strobe, and at most one code is emitted per sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irIn | input | 1 | Raw demodulated receiver line |
| globalEn | input | 1 | Block-level enable |
| rxEn | input | 1 | Receive-path enable |
| invertPol | input | 1 | 1 = invert the line before sampling |
| noiseThr | input | 6 | Minimum persistence, in samples, of a level change |
| idleThr | input | 8 | Idle timeout in units of 128 samples, minus one |
| codeValid | output | 1 | One-cycle strobe: `code` holds a new run code |
| code | output | 8 | {level, run length − 1} |
| packetEnd | output | 1 | One-cycle strobe with the final code of a packet |

## Verification
The assertions assume that `noiseThr` and `idleThr` change only while the block is disabled or idle. They also assume `TICK_DIV` is at least 2, so that two codes can never fall on adjacent cycles. The bench changes the thresholds only between cases, after each packet has closed. It drives the line in segments that are whole multiples of the sample period, so each segment length in samples does not depend on the prescaler phase. Every case ends with a space longer than the idle timeout, so the block is back in its idle state before the next case starts.

// File: rtl/ir_run_pkg.sv
package ir_run_pkg;

  // Status the datapath reports to the control on every cycle
  typedef struct packed {
    logic tick;      // sample instant this cycle
    logic fLevel;    // filtered level after this sample
    logic curLevel;  // level of the run being measured
    logic runZero;   // current chunk holds no samples
    logic runLast;   // current chunk is one sample short of full
    logic idleHit;   // this sample completes the idle timeout
  } pathStat_t;

  // Strobes the control issues to the datapath
  typedef struct packed {
    logic startRun;  // begin a new run at the filtered level
    logic incRun;    // count one more sample into the chunk
    logic clearRun;  // empty the chunk
    logic emitPrev;  // emit the chunk as it stands
    logic emitInc;   // emit the chunk including this sample
    logic incIdle;   // count one more space sample
    logic endPkt;    // close the packet
  } runCmd_t;

endpackage

// File: rtl/ir_run_path.sv
module ir_run_path
  import ir_run_pkg::*;
#(
  parameter int TICK_DIV  = 64,
  parameter int RUN_W     = 7,
  parameter int NOISE_W   = 6,
  parameter int IDLE_W    = 8,
  parameter int IDLE_UNIT = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enAll,
  input  logic               irIn,
  input  logic               invertPol,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  input  runCmd_t            cmd,
  output pathStat_t          stat,
  output logic               codeValid,
  output logic [RUN_W:0]     code,
  output logic               packetEnd
);

  localparam int PRE_W      = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int IDLE_SH    = $clog2(IDLE_UNIT);
  localparam int IDLE_CNT_W = IDLE_W + IDLE_SH + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = {RUN_W{1'b1}};

  // Two-stage input synchronizer
  logic [1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], irIn};
  end

  // Sample prescaler
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  assign tick = enAll && (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        preCnt <= '0;
    else if (!enAll || preCnt == PRE_LAST) preCnt <= '0;
    else                              preCnt <= preCnt + 1'b1;
  end

  // Glitch filter
  logic               rawBit;
  logic               fLevel;
  logic [NOISE_W-1:0] fCnt;
  logic [NOISE_W:0]   thrEff;
  logic [NOISE_W:0]   fCntInc;
  logic               fNext;
  logic               fAccept;

  assign rawBit  = syncQ[1] ^ invertPol;
  assign thrEff  = (noiseThr == '0) ? (NOISE_W+1)'(1) : {1'b0, noiseThr};
  assign fCntInc = {1'b0, fCnt} + 1'b1;
  assign fAccept = (rawBit != fLevel) && (fCntInc >= thrEff);
  assign fNext   = fAccept ? rawBit : fLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fLevel <= 1'b0;
      fCnt   <= '0;
    end else if (!enAll) begin
      fLevel <= 1'b0;
      fCnt   <= '0;
    end else if (tick) begin
      if (rawBit == fLevel || fAccept) fCnt <= '0;
      else                             fCnt <= fCntInc[NOISE_W-1:0];
      fLevel <= fNext;
    end
  end

  // Run and idle counters
  logic                  curLevel;
  logic [RUN_W-1:0]      runLen;
  logic [IDLE_CNT_W-1:0] idleCnt;
  logic [IDLE_CNT_W-1:0] idleLimit;

  assign idleLimit = ({{(IDLE_SH+1){1'b0}}, idleThr} + 1'b1) << IDLE_SH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel <= 1'b0;
      runLen   <= '0;
      idleCnt  <= '0;
    end else if (!enAll) begin
      curLevel <= 1'b0;
      runLen   <= '0;
      idleCnt  <= '0;
    end else begin
      if (cmd.startRun) begin
        curLevel <= fNext;
        runLen   <= RUN_W'(1);
        idleCnt  <= IDLE_CNT_W'(1);
      end else begin
        if (cmd.clearRun)     runLen <= '0;
        else if (cmd.incRun)  runLen <= runLen + 1'b1;
        if (cmd.endPkt)       idleCnt <= '0;
        else if (cmd.incIdle) idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stat.tick     = tick;
    stat.fLevel   = fNext;
    stat.curLevel = curLevel;
    stat.runZero  = (runLen == '0);
    stat.runLast  = (runLen == RUN_MAX);
    stat.idleHit  = ((idleCnt + 1'b1) == idleLimit);
  end

  // Output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeValid <= 1'b0;
      code      <= '0;
      packetEnd <= 1'b0;
    end else begin
      codeValid <= enAll && (cmd.emitPrev || cmd.emitInc);
      packetEnd <= enAll && cmd.endPkt;
      if (enAll && cmd.emitInc)       code <= {curLevel, runLen};
      else if (enAll && cmd.emitPrev) code <= {curLevel, runLen - 1'b1};
    end
  end

  // Checker state: a packet end has been seen and no code has followed yet
  logic afterEnd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          afterEnd <= 1'b0;
    else if (packetEnd) afterEnd <= 1'b1;
    else if (codeValid) afterEnd <= 1'b0;
  end

  p_no_code_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enAll) |-> (!codeValid && !packetEnd));

  p_end_is_full_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    packetEnd |-> (codeValid && code == {1'b0, RUN_MAX}));

  p_one_per_sample_r10: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> !codeValid);

  p_glitch_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, fCnt} < thrEff);

  p_first_after_end_is_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (afterEnd && codeValid) |-> code[RUN_W]);

endmodule

// File: rtl/ir_run_ctrl.sv
module ir_run_ctrl
  import ir_run_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enAll,
  input  pathStat_t stat,
  output runCmd_t   cmd
);

  logic active;

  always_comb begin
    cmd = '0;
    if (stat.tick) begin
      if (!active) begin
        // idle line: a packet opens only on the pulse level
        if (stat.fLevel) cmd.startRun = 1'b1;
      end else if (stat.fLevel != stat.curLevel) begin
        cmd.emitPrev = !stat.runZero;
        cmd.startRun = 1'b1;
      end else if (!stat.curLevel && stat.idleHit) begin
        cmd.emitInc  = 1'b1;
        cmd.endPkt   = 1'b1;
        cmd.clearRun = 1'b1;
      end else if (stat.runLast) begin
        cmd.emitInc  = 1'b1;
        cmd.clearRun = 1'b1;
        cmd.incIdle  = !stat.curLevel;
      end else begin
        cmd.incRun   = 1'b1;
        cmd.incIdle  = !stat.curLevel;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             active <= 1'b0;
    else if (!enAll)       active <= 1'b0;
    else if (cmd.startRun) active <= 1'b1;
    else if (cmd.endPkt)   active <= 1'b0;
  end

  p_open_on_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!active && cmd.startRun) |-> stat.fLevel);

  p_end_only_in_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.endPkt |-> (active && !stat.curLevel && !stat.fLevel));

endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler
  import ir_run_pkg::*;
#(
  parameter int TICK_DIV  = 64,
  parameter int RUN_W     = 7,
  parameter int NOISE_W   = 6,
  parameter int IDLE_W    = 8,
  parameter int IDLE_UNIT = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irIn,
  input  logic               globalEn,
  input  logic               rxEn,
  input  logic               invertPol,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  output logic               codeValid,
  output logic [RUN_W:0]     code,
  output logic               packetEnd
);

  logic      enAll;
  pathStat_t stat;
  runCmd_t   cmd;

  assign enAll = globalEn && rxEn;

  ir_run_path #(
    .TICK_DIV (TICK_DIV),
    .RUN_W    (RUN_W),
    .NOISE_W  (NOISE_W),
    .IDLE_W   (IDLE_W),
    .IDLE_UNIT(IDLE_UNIT)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .enAll    (enAll),
    .irIn     (irIn),
    .invertPol(invertPol),
    .noiseThr (noiseThr),
    .idleThr  (idleThr),
    .cmd      (cmd),
    .stat     (stat),
    .codeValid(codeValid),
    .code     (code),
    .packetEnd(packetEnd)
  );

  ir_run_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .enAll(enAll),
    .stat (stat),
    .cmd  (cmd)
  );

endmodule

// File: tb/tb_ir_run_sampler.sv
module tb_ir_run_sampler;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;
  localparam int MAX_CYC    = 150000;
  localparam int NCASE      = 5;
  // pulse, space, pulse lengths in samples; each case ends with a long space
  localparam int caseTab [NCASE][3] = '{
    '{5, 10, 3}, '{1, 1, 1}, '{128, 20, 7}, '{200, 5, 129}, '{40, 127, 2}};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       irIn = 1'b0;
  logic       globalEn = 1'b0;
  logic       rxEn = 1'b0;
  logic       invertPol = 1'b0;
  logic [5:0] noiseThr = 6'd1;
  logic [7:0] idleThr = 8'd0;
  logic       codeValid;
  logic [7:0] code;
  logic       packetEnd;

  ir_run_sampler #(.TICK_DIV(TICK)) dut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .globalEn(globalEn), .rxEn(rxEn),
    .invertPol(invertPol), .noiseThr(noiseThr), .idleThr(idleThr),
    .codeValid(codeValid), .code(code), .packetEnd(packetEnd));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // capture of emitted codes, sampled away from the active edge
  int       capN = 0;
  int       endCnt = 0;
  logic [7:0] capCode [0:63];
  bit       capEnd [0:63];
  always @(negedge clk) begin
    if (rstN && codeValid) begin
      if (capN < 64) begin
        capCode[capN] = code;
        capEnd[capN]  = packetEnd;
      end
      capN++;
    end
    if (rstN && packetEnd) endCnt++;
  end

  int         expN = 0;
  logic [7:0] expCode [0:63];
  bit         expEnd [0:63];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clearAll();
    capN = 0; endCnt = 0; expN = 0;
  endtask

  task automatic pushExp(input logic [7:0] c, input bit e);
    if (expN < 64) begin
      expCode[expN] = c;
      expEnd[expN]  = e;
    end
    expN++;
  endtask

  // R4: a run splits into full 0x7F chunks and a remainder
  task automatic addRun(input bit lvl, input int n);
    int rem = n;
    while (rem >= 128) begin
      pushExp({lvl, 7'h7F}, 1'b0);
      rem -= 128;
    end
    if (rem > 0) pushExp({lvl, 7'(rem - 1)}, 1'b0);
  endtask

  // R6: the closing space gives idleThr+1 full codes, the last with packetEnd
  task automatic addIdleEnd(input int ithr);
    for (int k = 0; k <= ithr; k++) pushExp(8'h7F, k == ithr);
  endtask

  // drive a logical level for n sample periods (invertPol applied on the wire)
  task automatic seg(input bit lvl, input int n);
    irIn = lvl ^ invertPol;
    repeat (n * TICK) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    check(capN == expN, tag, "code count", capN, expN);
    check(endCnt == 1 || expN == 0, tag, "packetEnd count", endCnt, 1);
    for (int i = 0; i < expN && i < capN && i < 64; i++) begin
      check(capCode[i] == expCode[i], tag, $sformatf("code[%0d]", i),
            capCode[i], expCode[i]);
      check(capEnd[i] == expEnd[i], tag, $sformatf("end[%0d]", i),
            capEnd[i], expEnd[i]);
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: outputs at zero during reset
    check(codeValid == 0 && packetEnd == 0 && code == 0, "R9", "outputs in reset",
          {codeValid, packetEnd, code}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(codeValid == 0 && packetEnd == 0 && code == 0, "R9", "outputs after reset",
          {codeValid, packetEnd, code}, 0);
    globalEn = 1'b1; rxEn = 1'b1;

    // R7: an idle (space) line produces nothing
    clearAll();
    seg(0, 300);
    check(capN == 0 && endCnt == 0, "R7", "idle line codes", capN, 0);

    // table walk: R1 R2 R4 R6 (noise 1, idle threshold 0)
    for (int c = 0; c < NCASE; c++) begin
      clearAll();
      seg(1, caseTab[c][0]); seg(0, caseTab[c][1]);
      seg(1, caseTab[c][2]); seg(0, 200);
      addRun(1, caseTab[c][0]); addRun(0, caseTab[c][1]);
      addRun(1, caseTab[c][2]); addIdleEnd(0);
      compare($sformatf("R1 R2 R4 R6 case %0d", c));
    end

    // R3: inverted receiver gives the same codes
    invertPol = 1'b1;
    seg(0, 10);
    clearAll();
    seg(1, 6); seg(0, 9); seg(1, 130); seg(0, 200);
    addRun(1, 6); addRun(0, 9); addRun(1, 130); addIdleEnd(0);
    compare("R3");
    invertPol = 1'b0;
    seg(0, 10);

    // R5: short space inside a pulse is merged, threshold-length pulse passes
    noiseThr = 6'd3;
    clearAll();
    seg(1, 10); seg(0, 2); seg(1, 10); seg(0, 200);
    addRun(1, 22); addIdleEnd(0);
    compare("R5 merge");
    clearAll();
    seg(1, 3); seg(0, 200);
    addRun(1, 3); addIdleEnd(0);
    compare("R5 threshold");
    clearAll();
    seg(1, 2); seg(0, 200);
    check(capN == 0 && endCnt == 0, "R5", "sub-threshold pulse codes", capN, 0);
    noiseThr = 6'd1;

    // R6 R7: longer timeout, a space below it does not close the packet
    idleThr = 8'd1;
    clearAll();
    seg(1, 4); seg(0, 200); seg(1, 4); seg(0, 300);
    addRun(1, 4); addRun(0, 200); addRun(1, 4); addIdleEnd(1);
    compare("R6 R7 long timeout");
    idleThr = 8'd0;

    // R8: either enable low blocks all output
    clearAll();
    rxEn = 1'b0;
    seg(1, 10); seg(0, 10); seg(1, 10); seg(0, 200);
    rxEn = 1'b1; globalEn = 1'b0;
    seg(1, 10); seg(0, 200);
    globalEn = 1'b1;
    check(capN == 0 && endCnt == 0, "R8", "codes while disabled", capN, 0);

    // R8: disabling mid-packet drops it
    clearAll();
    seg(1, 20);
    rxEn = 1'b0;
    seg(0, 5);
    rxEn = 1'b1;
    seg(0, 200);
    check(capN == 0 && endCnt == 0, "R8", "dropped packet codes", capN, 0);

    // R10 and block still working after the enable tests
    clearAll();
    seg(1, 2); seg(0, 1); seg(1, 1); seg(0, 200);
    addRun(1, 2); addRun(0, 1); addRun(1, 1); addIdleEnd(0);
    compare("R10 R2 back-to-back");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule